// File: doc/BRIEF.md
# Computation Unit Operand Handshake

This block walks one instruction through a small execution unit. An issue pulse captures an operation code and two 16-bit source operands. The unit then asks an external scheduler for permission to read each operand, using one request bit per operand. Each bit stays up until its own grant bit comes back.

When the last operand has been granted, the unit spends one cycle in a built-in ALU and latches the result. It then raises a single write request. The result is presented, qualified by a valid strobe, in the cycle where the write grant arrives, and the unit returns to idle on the next edge.

A kill input abandons the instruction at any point. It drops every request and the pending result on the next edge.

Top module: `cu_opshake`

## Requirements
- R1: While reset (synchronous, active high) is applied and in the first cycle after it, `rd_req_o` is 0, `wr_req_o` is 0, `busy_o` is 0 and `res_vld_o` is 0.
- R2: An issue pulse seen at an edge while the unit is idle, with kill low, captures `op_i`, `src_a_i` and `src_b_i`. In the next cycle both `rd_req_o` bits and `busy_o` are high. An issue pulse while busy changes nothing.
- R3: Read request bit i (bit 0 for operand A, bit 1 for operand B) stays high until an edge where `rd_grant_i[i]` is high, and is low after that edge. A grant bit whose request is already low has no effect.
- R4: No read request bit is ever high unless an issue pulse has been accepted since reset.
- R5: If the last outstanding read grant is taken at the edge ending cycle t, then `rd_req_o` is 0 in cycle t+1 (the compute cycle) and `wr_req_o` is high from cycle t+2. Read and write requests are never high together.
- R6: `wr_req_o` stays high until a cycle with `wr_grant_i` high. In that cycle `res_vld_o` is high and `res_o` holds the result. In the following cycle `wr_req_o` and `busy_o` are low. `res_vld_o` is low in every other cycle.
- R7: The result is computed from the captured operands, modulo 2^16, where `op_i` encodes 00 = A+B, 01 = A-B, 10 = A AND B, and 11 = A XOR B.
- R8: A cycle with `kill_i` high makes all read requests, `wr_req_o` and `busy_o` low in the next cycle, whatever the phase. In that cycle `res_vld_o` is low. Kill takes priority over a coincident issue pulse or grant.
- R9: `busy_o` is high from the cycle after an accepted issue until the cycle after the write grant or a kill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Issue pulse |
| op_i | input | 2 | Operation code |
| src_a_i | input | 16 | Source operand A |
| src_b_i | input | 16 | Source operand B |
| rd_grant_i | input | 2 | Per-operand read grants |
| wr_grant_i | input | 1 | Write grant |
| kill_i | input | 1 | Abort current instruction |
| rd_req_o | output | 2 | Per-operand read requests |
| wr_req_o | output | 1 | Write request |
| busy_o | output | 1 | Instruction in flight |
| res_o | output | 16 | Result |
| res_vld_o | output | 1 | Result valid for this cycle |

## Verification
Two situations are hard to reach from the ports. The first is a kill landing on exactly the single compute cycle. The second is a kill arriving in the same cycle as the write grant. Either one needs the read grants to be timed precisely. Directed sequences release the grants one bit at a time, in both orders, to count down to those cycles. A long randomized phase with sparse kills and independent grant bits then covers the remaining overlaps, against a cycle-level reference model.

// File: rtl/cu_pkg.sv
package cu_pkg;
    localparam int CU_NSRC = 2;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_XOR = 2'b11
    } cu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_READ  = 2'b01,
        ST_EXEC  = 2'b10,
        ST_WRITE = 2'b11
    } cu_st_e;
endpackage

// File: rtl/cu_alu.sv
module cu_alu
    import cu_pkg::*;
#(
    parameter int DW = 16
) (
    input  cu_op_e        op_i,
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    output logic [DW-1:0] y_o
);
    always_comb begin
        unique case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_AND:  y_o = a_i & b_i;
            default: y_o = a_i ^ b_i;
        endcase
    end
endmodule

// File: rtl/cu_rdtrack.sv
module cu_rdtrack #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic            kill_i,
    input  logic [NSRC-1:0] grant_i,
    output logic [NSRC-1:0] req_o,
    output logic            done_o
);
    logic [NSRC-1:0] req_d, req_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        assign req_d[i] = kill_i ? 1'b0 : (load_i ? 1'b1 : (req_q[i] & ~grant_i[i]));

        AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
            (req_q[i] && !grant_i[i] && !kill_i) |=> req_q[i]); // R3
        AST_RD_GRANT_CLEAR: assert property (@(posedge clk) disable iff (rst)
            (req_q[i] && grant_i[i]) |=> !req_q[i]); // R3
    end

    always_ff @(posedge clk) begin
        if (rst) req_q <= '0;
        else     req_q <= req_d;
    end

    assign req_o  = req_q;
    assign done_o = (|req_q) & ~(|(req_q & ~grant_i)) & ~kill_i;
endmodule

// File: rtl/cu_opshake.sv
module cu_opshake
    import cu_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               issue_i,
    input  logic [1:0]         op_i,
    input  logic [DW-1:0]      src_a_i,
    input  logic [DW-1:0]      src_b_i,
    input  logic [CU_NSRC-1:0] rd_grant_i,
    input  logic               wr_grant_i,
    input  logic               kill_i,
    output logic [CU_NSRC-1:0] rd_req_o,
    output logic               wr_req_o,
    output logic               busy_o,
    output logic [DW-1:0]      res_o,
    output logic               res_vld_o
);
    typedef struct packed {
        cu_st_e        st;
        cu_op_e        op;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [DW-1:0] res;
        logic          wr;
    } core_t;

    core_t         s_d, s_q;
    logic          rd_load, rd_done;
    logic [DW-1:0] alu_y;

    assign rd_load = (s_q.st == ST_IDLE) & issue_i & ~kill_i;

    cu_rdtrack #(.NSRC(CU_NSRC)) u_rd (
        .clk     (clk),
        .rst     (rst),
        .load_i  (rd_load),
        .kill_i  (kill_i),
        .grant_i (rd_grant_i),
        .req_o   (rd_req_o),
        .done_o  (rd_done)
    );

    cu_alu #(.DW(DW)) u_alu (
        .op_i (s_q.op),
        .a_i  (s_q.a),
        .b_i  (s_q.b),
        .y_o  (alu_y)
    );

    always_comb begin
        s_d = s_q;
        if (kill_i) begin
            s_d.st  = ST_IDLE;
            s_d.wr  = 1'b0;
            s_d.res = '0;
        end else begin
            unique case (s_q.st)
                ST_IDLE: if (issue_i) begin
                    s_d.st = ST_READ;
                    s_d.op = cu_op_e'(op_i);
                    s_d.a  = src_a_i;
                    s_d.b  = src_b_i;
                end
                ST_READ: if (rd_done) s_d.st = ST_EXEC;
                ST_EXEC: begin
                    s_d.res = alu_y;
                    s_d.wr  = 1'b1;
                    s_d.st  = ST_WRITE;
                end
                default: if (wr_grant_i) begin
                    s_d.st = ST_IDLE;
                    s_d.wr = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign wr_req_o  = s_q.wr;
    assign busy_o    = (s_q.st != ST_IDLE);
    assign res_o     = s_q.res;
    assign res_vld_o = s_q.wr & wr_grant_i & ~kill_i;

    logic seen_issue_q;
    always_ff @(posedge clk) begin
        if (rst)          seen_issue_q <= 1'b0;
        else if (issue_i) seen_issue_q <= 1'b1;
    end

    AST_REQ_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (|rd_req_o) |-> seen_issue_q); // R4
    AST_ISSUE_ARMS: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && issue_i && !kill_i) |=> (rd_req_o == '1 && busy_o)); // R2
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !((|rd_req_o) && wr_req_o)); // R5
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && !wr_grant_i && !kill_i) |=> wr_req_o); // R6
    AST_WR_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && wr_grant_i && !kill_i) |=> (!wr_req_o && !busy_o)); // R6
    AST_VLD_QUAL: assert property (@(posedge clk) disable iff (rst)
        res_vld_o |-> (wr_req_o && wr_grant_i)); // R6
    AST_KILL_FLUSH: assert property (@(posedge clk) disable iff (rst)
        kill_i |=> (rd_req_o == '0 && !wr_req_o && !busy_o)); // R8
endmodule

// File: tb/cu_opshake_test.sv
module cu_opshake_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] sa = '0;
    logic [15:0] sb = '0;
    logic [1:0]  rg = '0;
    logic        wg = 1'b0;
    logic        kill = 1'b0;
    logic [1:0]  rd_req;
    logic        wr_req, busy, res_vld;
    logic [15:0] res;

    always #5 clk = ~clk;

    cu_opshake uut (
        .clk(clk), .rst(rst), .issue_i(issue), .op_i(op),
        .src_a_i(sa), .src_b_i(sb), .rd_grant_i(rg), .wr_grant_i(wg),
        .kill_i(kill), .rd_req_o(rd_req), .wr_req_o(wr_req),
        .busy_o(busy), .res_o(res), .res_vld_o(res_vld)
    );

    // Reference model: phase 0 idle, 1 read, 2 compute, 3 write
    int    m_ph = 0;
    int    m_rd = 0;
    int    m_wr = 0;
    int    m_op = 0;
    int    m_a = 0, m_b = 0, m_res = 0;
    int    n_chk = 0, n_fail = 0;
    bit    finished = 0;
    string scen = "R1";

    function automatic int calc(int o, int a, int b);
        case (o)
            0: return (a + b) & 16'hFFFF;
            1: return (a - b) & 16'hFFFF;
            2: return a & b;
            default: return a ^ b;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst || kill) begin
            m_ph = 0; m_rd = 0; m_wr = 0;
            if (rst) m_res = 0;
        end else begin
            case (m_ph)
                0: if (issue) begin
                    m_ph = 1; m_rd = 3; m_op = int'(op); m_a = int'(sa); m_b = int'(sb);
                end
                1: begin
                    m_rd = m_rd & ~int'(rg);
                    if (m_rd == 0) m_ph = 2;
                end
                2: begin
                    m_res = calc(m_op, m_a, m_b); m_wr = 1; m_ph = 3;
                end
                default: if (wg) begin m_ph = 0; m_wr = 0; end
            endcase
        end
    end

    task automatic chk(string req, string sig, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s (scenario %s) at %0t: actual %0h expected %0h",
                     req, sig, scen, $time, act, exp);
        end
    endtask

    task automatic cyc(bit i, int o, int a, int b, int g, bit w, bit k);
        @(negedge clk);
        issue = i; op = 2'(o); sa = 16'(a); sb = 16'(b);
        rg = 2'(g); wg = w; kill = k;
        #1;
        begin
            int vld_exp;
            vld_exp = (m_ph == 3 && wg && !kill) ? 1 : 0;
            chk("R3", "rd_req", int'(rd_req), m_rd);
            chk("R5", "wr_req", int'(wr_req), m_wr);
            chk("R9", "busy", int'(busy), (m_ph != 0) ? 1 : 0);
            chk("R6", "res_vld", int'(res_vld), vld_exp);
            if (vld_exp == 1) chk("R7", "res", int'(res), m_res);
        end
    endtask

    task automatic idle(int n);
        for (int j = 0; j < n; j++) cyc(0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        scen = "R1";
        for (int j = 0; j < 3; j++) cyc(0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); rst = 1'b0; #1;
        chk("R1", "rd_req after reset", int'(rd_req), 0);
        chk("R1", "busy after reset", int'(busy), 0);
        chk("R1", "wr_req after reset", int'(wr_req), 0);

        scen = "R4";
        for (int j = 0; j < 4; j++) cyc(0, 0, 0, 0, 3, 1, 0);
        chk("R4", "rd_req without issue", int'(rd_req), 0);

        scen = "R2";
        cyc(1, 0, 5, 5, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R2", "rd_req after issue", int'(rd_req), 3);
        cyc(1, 3, 16'h1234, 16'h4321, 0, 0, 0);
        cyc(0, 0, 0, 0, 3, 0, 0);
        idle(2);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R7", "add 5+5", int'(res), 10);
        idle(2);

        scen = "R3";
        cyc(1, 1, 16'h0100, 16'h0003, 0, 0, 0);
        cyc(0, 0, 0, 0, 2, 0, 0);
        cyc(0, 0, 0, 0, 2, 0, 0);
        chk("R3", "bit1 granted, bit0 pending", int'(rd_req), 1);
        idle(2);
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R5", "compute cycle", int'(rd_req) + int'(wr_req), 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R5", "write request raised", int'(wr_req), 1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        idle(1);

        scen = "R7";
        cyc(1, 2, 16'hF0F0, 16'h3C3C, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 0);
        cyc(0, 0, 0, 0, 2, 0, 0);
        idle(2);
        cyc(0, 0, 0, 0, 0, 1, 0);
        cyc(1, 0, 16'hFFFF, 16'h0001, 0, 0, 0);
        cyc(0, 0, 0, 0, 3, 0, 0);
        idle(1);
        cyc(0, 0, 0, 0, 0, 1, 0);
        chk("R7", "add wraps", int'(res), 0);

        scen = "R8";
        cyc(1, 0, 1, 2, 0, 0, 0);
        cyc(0, 0, 0, 0, 1, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R8", "kill in read", int'(busy) + int'(rd_req), 0);
        cyc(1, 0, 1, 2, 0, 0, 0);
        cyc(0, 0, 0, 0, 3, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R8", "kill in compute", int'(wr_req) + int'(busy), 0);
        cyc(1, 1, 9, 4, 0, 0, 0);
        cyc(0, 0, 0, 0, 3, 0, 0);
        idle(1);
        cyc(0, 0, 0, 0, 0, 1, 1);
        chk("R8", "kill with write grant", int'(res_vld), 0);
        cyc(1, 0, 1, 1, 0, 0, 1);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R8", "kill beats issue", int'(busy), 0);

        scen = "R9";
        for (int j = 0; j < 3000; j++) begin
            cyc(($urandom % 3) == 0, int'($urandom % 4), int'($urandom % 65536),
                int'($urandom % 65536), int'($urandom % 4), ($urandom % 2) == 1,
                ($urandom % 20) == 0);
        end
        idle(2);

        if (!finished) begin
            finished = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule